// File: doc/BRIEF.md
# Sync Output Formatter with Coast Control

This block rebuilds the horizontal and vertical sync outputs of a video capture front end from a one-clock lock strobe and a raw vertical integrator level, both timed to the pixel clock. It produces a regenerated horizontal sync pulse and a horizontal output pulse of programmable width. The horizontal output pulse can be anchored on the lock edge in two ways: its start sits on the edge and the width grows later in time, or its end sits on the edge and the width grows earlier in time. To place the pulse before an edge that has not arrived yet, the block predicts that edge from the period of the previous line.

The vertical output is either resampled only at regenerated horizontal sync edges or passed through directly. An external coast signal, whose polarity is selectable, makes the block ignore incoming lock strobes. While coast is active, the horizontal timing of the last measured line keeps running on its own. One configuration byte selects these modes and also switches the three sync outputs between driving and high impedance through their output enables.

Top module: `sync_out_fmt`

## Requirements
- R1: When configuration bit 0 is 1, all three output enables are 0 (high impedance). When bit 0 is 0, all three are 1.
- R2: The internal coast output is active high. It equals the external coast input when configuration bit 1 is 0, and its inverse when bit 1 is 1.
- R3: Each accepted lock strobe makes the regenerated horizontal sync output 1 for exactly one cycle, in the cycle after the strobe.
- R4: With configuration bit 2 at 1 (leading-edge lock), the horizontal output goes high in the same cycle as the regenerated sync pulse and stays high for exactly `hs_width` cycles. A width of 0 gives no pulse.
- R5: With configuration bit 2 at 0 (trailing-edge lock), once a line period has been measured, the horizontal output is high for exactly `hs_width` cycles and falls in the cycle the regenerated sync pulse rises. The line period is the number of clocks between the last two accepted strobes.
- R6: In trailing-edge lock, a width equal to or larger than the line period is clamped. The output then rises one cycle after the previous sync pulse and stays high for the line period minus one cycle.
- R7: With configuration bit 4 at 0, the vertical output takes the raw vertical level sampled together with each regenerated horizontal sync edge, and it changes at no other time.
- R8: With configuration bit 4 at 1, the vertical output follows the raw vertical level one cycle later.
- R9: While coast is active, lock strobes are ignored. Regenerated sync pulses continue every measured-period cycles from the last accepted edge, and the block follows new strobes again once coast is released.
- R10: Configuration bits 3, 5, 6 and 7 have no effect on any output.
- R11: After reset, all three sync outputs are 0. Until two strobes have been accepted, there is no trailing-edge pulse and no freewheel pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_lock | input | 1 | One-cycle strobe marking the selected horizontal lock edge |
| vs_raw | input | 1 | Raw vertical integrator output |
| coast_ext | input | 1 | External coast request, polarity set by configuration bit 1 |
| cfg | input | 8 | Configuration byte: bit 0 output disable, bit 1 coast polarity, bit 2 lock anchor, bit 4 vertical bypass, other bits reserved |
| hs_width | input | WIDTH_W | Horizontal output pulse width in pixel clocks |
| hsout | output | 1 | Programmable-width horizontal output pulse |
| hsyncout | output | 1 | Regenerated horizontal sync pulse |
| vsyncout | output | 1 | Vertical sync output |
| hsout_oe | output | 1 | Output enable for hsout |
| hsyncout_oe | output | 1 | Output enable for hsyncout |
| vsyncout_oe | output | 1 | Output enable for vsyncout |
| coast | output | 1 | Internal coast, active high |

## Verification
The assertions check four properties on every cycle:
- In leading-edge lock, the horizontal output never rises except together with a sync pulse.
- In trailing-edge lock, it never falls except together with a sync pulse.
- In retimed mode, the vertical output holds still between sync pulses.
- No sync pulse appears from a strobe ignored under coast, or from freewheeling before a period is known.

Only the bench scenarios can show the exact pulse lengths, the clamp for long widths, the prediction from the previous line's period, the freewheel spacing across a stray strobe, and the absence of any effect from the reserved bits.

// File: rtl/sync_out_fmt.sv
module sync_out_fmt #(
  parameter int WIDTH_W = 8,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_lock,
  input  logic               vs_raw,
  input  logic               coast_ext,
  input  logic [7:0]         cfg,
  input  logic [WIDTH_W-1:0] hs_width,
  output logic               hsout,
  output logic               hsyncout,
  output logic               vsyncout,
  output logic               hsout_oe,
  output logic               hsyncout_oe,
  output logic               vsyncout_oe,
  output logic               coast
);

  localparam logic [CNT_W-1:0]   ONE_C   = 1;
  localparam logic [WIDTH_W-1:0] ONE_W   = 1;
  localparam logic [CNT_W-1:0]   CNT_TOP = '1;
  localparam logic [CNT_W-1:0]   CNT_SAT = CNT_TOP - ONE_C;

  wire out_off   = cfg[0];
  wire coast_inv = cfg[1];
  wire lead_lock = cfg[2];
  wire vs_bypass = cfg[4];
  wire unused_rsvd = ^{cfg[7:5], cfg[3]};

  logic [CNT_W-1:0]   line_cnt, period;
  logic               seen, period_ok;
  logic [WIDTH_W-1:0] rem;

  assign coast       = coast_ext ^ coast_inv;
  assign hsout_oe    = !out_off;
  assign hsyncout_oe = !out_off;
  assign vsyncout_oe = !out_off;

  wire in_ev   = !coast && hs_lock;
  wire free_ev = coast && period_ok && (line_cnt == period - ONE_C);
  wire line_ev = in_ev || free_ev;

  wire [CNT_W-1:0] wid_c       = {{(CNT_W-WIDTH_W){1'b0}}, hs_width};
  wire [CNT_W-1:0] trail_start = (wid_c >= period) ? '0 : (period - wid_c - ONE_C);
  wire trail_go = !lead_lock && period_ok && (hs_width != '0) && (line_cnt == trail_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      period    <= '0;
      seen      <= 1'b0;
      period_ok <= 1'b0;
    end else begin
      if (line_ev)
        line_cnt <= '0;
      else if (line_cnt != CNT_SAT)
        line_cnt <= line_cnt + ONE_C;
      if (in_ev) begin
        seen <= 1'b1;
        if (seen) begin
          period    <= line_cnt + ONE_C;
          period_ok <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsyncout <= 1'b0;
      vsyncout <= 1'b0;
    end else begin
      hsyncout <= line_ev;
      if (vs_bypass || line_ev)
        vsyncout <= vs_raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsout <= 1'b0;
      rem   <= '0;
    end else if (lead_lock) begin
      if (line_ev) begin
        hsout <= (hs_width != '0);
        rem   <= (hs_width == '0) ? '0 : hs_width - ONE_W;
      end else if (rem != '0) begin
        rem <= rem - ONE_W;
      end else begin
        hsout <= 1'b0;
      end
    end else begin
      rem <= '0;
      if (line_ev)
        hsout <= 1'b0;
      else if (trail_go)
        hsout <= 1'b1;
    end
  end

  assert_lead_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hsout) && $past(lead_lock)) |-> hsyncout);

  assert_trail_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hsout) && !$past(lead_lock)) |-> hsyncout);

  assert_vs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(vs_bypass) && !hsyncout) |-> $stable(vsyncout));

  assert_coast_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (coast && hs_lock && !free_ev) |=> !hsyncout);

  assert_no_free_unlocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (coast && !period_ok) |=> !hsyncout);

  assert_hsync_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hsyncout |-> ($past(hs_lock) || $past(coast)));

endmodule

// File: tb/sync_out_fmt_bench.sv
module sync_out_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROW = 6;
  localparam logic [7:0] T_CFG [0:NROW-1] = '{8'h04, 8'h04, 8'h00, 8'h00, 8'hEC, 8'h00};
  localparam int         T_W   [0:NROW-1] = '{3, 0, 4, 20, 5, 1};
  localparam int         T_P   [0:NROW-1] = '{10, 10, 12, 8, 9, 6};
  localparam int         T_LEN [0:NROW-1] = '{3, 0, 4, 7, 5, 1};

  logic clk = 0, rst_n = 0, hs_lock = 0, vs_raw = 0, coast_ext = 0;
  logic [7:0] cfg = 0;
  logic [7:0] hs_width = 0;
  logic hsout, hsyncout, vsyncout, hsout_oe, hsyncout_oe, vsyncout_oe, coast;
  logic sh [0:79];
  logic sy [0:79];
  logic sv [0:79];
  int total = 0, bad = 0;

  sync_out_fmt u_sync_out_fmt (
    .clk(clk), .rst_n(rst_n), .hs_lock(hs_lock), .vs_raw(vs_raw), .coast_ext(coast_ext),
    .cfg(cfg), .hs_width(hs_width), .hsout(hsout), .hsyncout(hsyncout), .vsyncout(vsyncout),
    .hsout_oe(hsout_oe), .hsyncout_oe(hsyncout_oe), .vsyncout_oe(vsyncout_oe), .coast(coast));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; hs_lock = 0; coast_ext = 0; vs_raw = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11: outputs quiet in reset
    repeat (2) @(negedge clk);
    check(hsout == 0 && hsyncout == 0 && vsyncout == 0, "R11 reset outputs",
          {hsout, hsyncout, vsyncout}, 0);
    rst_n = 1;

    for (int r = 0; r < NROW; r++) begin
      int p, w, cnt;
      p = T_P[r]; w = T_W[r];
      do_reset();
      cfg = T_CFG[r]; hs_width = 8'(w);
      for (int i = 0; i <= 4*p + 1; i++) begin
        @(negedge clk);
        sh[i] = hsout; sy[i] = hsyncout; sv[i] = vsyncout;
        hs_lock = (i % p == 0);
      end
      hs_lock = 0;
      cnt = 0;
      for (int i = 3*p + 1; i <= 4*p; i++) if (sh[i]) cnt++;
      check(sy[3*p+1] == 1 && sy[3*p+2] == 0, "R3 single sync pulse", {sy[3*p+1], sy[3*p+2]}, 2);
      if (cfg[2]) begin
        check(cnt == T_LEN[r], (r == 4) ? "R10 R4 length with reserved bits" : "R4 lead length", cnt, T_LEN[r]);
        check(sh[3*p+1] == (w != 0), "R4 lead start", sh[3*p+1], (w != 0));
      end else begin
        check(cnt == T_LEN[r], (w >= p) ? "R6 clamped length" : "R5 trail length", cnt, T_LEN[r]);
        check(sh[4*p] == 1 && sh[4*p+1] == 0 && sy[4*p+1] == 1, "R5 trail end on sync edge",
              {sh[4*p], sh[4*p+1], sy[4*p+1]}, 3'b101);
      end
    end

    // R1: output enables
    @(negedge clk); cfg = 8'h01; #1;
    check(!hsout_oe && !hsyncout_oe && !vsyncout_oe, "R1 disabled",
          {hsout_oe, hsyncout_oe, vsyncout_oe}, 0);
    cfg = 8'h00; #1;
    check(hsout_oe && hsyncout_oe && vsyncout_oe, "R1 enabled",
          {hsout_oe, hsyncout_oe, vsyncout_oe}, 7);

    // R2: coast polarity
    for (int k = 0; k < 4; k++) begin
      cfg = {6'b0, k[1], 1'b0}; coast_ext = k[0]; #1;
      check(coast == (k[0] ^ k[1]), "R2 coast polarity", coast, k[0] ^ k[1]);
    end
    coast_ext = 0; cfg = 0;

    // R11: no trail pulse or freewheel before a period is known
    do_reset();
    cfg = 8'h00; hs_width = 2;
    @(negedge clk); hs_lock = 1;
    @(negedge clk); hs_lock = 0;
    begin
      int hi = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (hsout) hi++; end
      check(hi == 0, "R11 no trail pulse unlocked", hi, 0);
      coast_ext = 1; hi = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (hsyncout) hi++; end
      check(hi == 0, "R11 no freewheel unlocked", hi, 0);
      coast_ext = 0;
    end

    // R9: freewheel under coast
    do_reset();
    cfg = 8'h04; hs_width = 2;
    for (int i = 0; i <= 36; i++) begin
      @(negedge clk);
      sy[i] = hsyncout;
      hs_lock = (i == 0 || i == 7 || i == 14 || i == 17 || i == 32);
      coast_ext = (i >= 15 && i <= 30);
    end
    hs_lock = 0; coast_ext = 0;
    check(sy[15] == 1, "R9 last accepted edge", sy[15], 1);
    check(sy[18] == 0, "R9 stray strobe ignored", sy[18], 0);
    check(sy[22] == 1 && sy[29] == 1, "R9 freewheel pulses", {sy[22], sy[29]}, 3);
    begin
      int hi = 0;
      for (int i = 16; i <= 31; i++) if (sy[i]) hi++;
      check(hi == 2, "R9 freewheel count", hi, 2);
    end
    check(sy[33] == 1 && sy[36] == 0, "R9 follows input after coast", {sy[33], sy[36]}, 2);

    // R7: retimed vertical
    do_reset();
    cfg = 8'h00; hs_width = 0;
    for (int i = 0; i <= 21; i++) begin
      @(negedge clk);
      sv[i] = vsyncout;
      hs_lock = (i == 0 || i == 10 || i == 20);
      if (i == 3) vs_raw = 1;
    end
    hs_lock = 0;
    check(sv[4] == 0 && sv[9] == 0, "R7 hold between edges", {sv[4], sv[9]}, 0);
    check(sv[11] == 1, "R7 update on sync edge", sv[11], 1);

    // R8: raw vertical
    cfg = 8'h10;
    @(negedge clk); vs_raw = 0;
    @(negedge clk);
    check(vsyncout == 0, "R8 raw low", vsyncout, 0);
    vs_raw = 1;
    @(negedge clk);
    check(vsyncout == 1, "R8 raw high", vsyncout, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule